// File: doc/BRIEF.md
# Halting debug controller

This block decides when a processing element stops running its program and enters a halted debug state, and it gives an external debugger a small register window while the element is halted. Breakpoint, watchpoint and external halt-request events are qualified by their own enable bits and then by an authentication level. That level allows halting in non-secure execution only, or in both non-secure and secure execution. An event that is not allowed is dropped.

While halted, the block keeps instruction fetch stalled and interrupts masked. Instructions come one at a time from an injection register that the debugger writes. Each write raises a one-cycle issue strobe towards the core, and the core acknowledges when the instruction completes. Two single-entry mailboxes carry data in each direction between the debugger and the core. A restart request written by the debugger returns the element to normal execution, but only once no injected instruction is outstanding.

Top module: `hdbg_ctrl`

## Requirements
- R1: After reset the element is not halted, `fetch_stall`, `irq_mask` and `itr_issue` are low, both mailboxes are empty, and the status word reads zero.
- R2: A breakpoint or watchpoint event halts the element only when the hardware-halt enable bit (control bit 0) is one. With that bit at zero the event is ignored.
- R3: An external halt request has its own enable bit (control bit 1). The halt cause is 1 for a breakpoint, 2 for a watchpoint and 3 for an external request. When several events arrive in the same cycle, the cause is chosen with priority breakpoint, then watchpoint, then external request.
- R4: The 2-bit `auth_lvl` gates halting. At 0 nothing halts. At 1 halting is allowed only while `sec_state` is 0. At 2 or 3 halting is allowed in either security state. A blocked event is dropped and does not halt the element later, even if permission is granted afterwards.
- R5: The cycle after an accepted event, `halted`, `fetch_stall` and `irq_mask` are all high, and they stay high until a restart. Events that arrive while halted do not change the recorded cause.
- R6: A bus write to address 1 while halted loads the injection register, sets its full flag (status bit 12) and pulses `itr_issue` for exactly one cycle with the word on `itr_insn`. `itr_done` clears the full flag. A write to address 1 while not halted is ignored.
- R7: A write to address 1 while the full flag is set leaves `itr_insn` unchanged, raises no issue strobe and sets the sticky overrun bit (status bit 8).
- R8: A bus write to address 2 fills the debugger-to-core mailbox (`core_rx_full`, `core_rx_data`, status bit 13), and `core_rx_rd` empties it. A bus write while it is full keeps the old data and sets sticky bit 9.
- R9: `core_tx_wr` fills the core-to-debugger mailbox (status bit 14), and a bus read of address 3 returns its data and empties it. A core write while it is full keeps the old data and sets sticky bit 10.
- R10: A control write with bit 2 set while halted and with the injection register empty ends the halted state on the next cycle and drops `fetch_stall` and `irq_mask`. While the injection register is full, the restart request is ignored.
- R11: Reading address 0 returns the enables in bits 1:0, `halted` in bit 4, the cause in bits 6:5, the sticky errors in bits 10:8 and the full flags in bits 14:12. Writing a one to an error bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bkpt | input | 1 | Breakpoint hit event |
| ev_wpt | input | 1 | Watchpoint hit event |
| ev_ereq | input | 1 | External halt request event |
| sec_state | input | 1 | 1 while the element executes in secure state |
| auth_lvl | input | 2 | Debugger authentication level |
| bus_wr | input | 1 | Debug bus write strobe |
| bus_rd | input | 1 | Debug bus read strobe |
| bus_addr | input | ADDR_W | Debug bus word address |
| bus_wdata | input | DATA_W | Debug bus write data |
| bus_rdata | output | DATA_W | Debug bus read data, valid in the cycle of `bus_rd` |
| halted | output | 1 | Element is in debug state |
| fetch_stall | output | 1 | Stop fetching from the program counter |
| irq_mask | output | 1 | Block interrupts |
| itr_issue | output | 1 | One-cycle strobe: execute `itr_insn` |
| itr_insn | output | DATA_W | Injected instruction |
| itr_done | input | 1 | Core finished the injected instruction |
| core_rx_rd | input | 1 | Core takes the debugger-to-core word |
| core_rx_data | output | DATA_W | Debugger-to-core word |
| core_rx_full | output | 1 | Debugger-to-core word waiting |
| core_tx_wr | input | 1 | Core writes a word for the debugger |
| core_tx_data | input | DATA_W | Core-to-debugger word |

## Verification
A wrong halt state shows up on `fetch_stall` and `irq_mask` one clock after the event or the restart write, so each gating case is checked at the first falling edge after it. A wrong cause or a lost sticky bit is visible in the next status read, and the bench reads status straight after each stimulus. A wrong injection-register flag shows up as an extra or missing `itr_issue` pulse, or as a restart that takes effect too early. A mailbox that clears at the wrong time shows up as wrong data or a wrong full flag on the very next cycle.

// File: rtl/hdbg_pkg.sv
// Shared definitions for the halting debug controller.
// Assumes word-addressed debug bus; addresses and bit positions below are the
// software-visible layout.
package hdbg_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_BKPT = 2'd1,
        CAUSE_WPT  = 2'd2,
        CAUSE_EREQ = 2'd3
    } cause_e;

    localparam logic [1:0] AUTH_NS  = 2'd1;
    localparam logic [1:0] AUTH_ALL = 2'd2;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_ITR  = 1;
    localparam int ADDR_DN   = 2;
    localparam int ADDR_UP   = 3;

    localparam int B_HWEN    = 0;
    localparam int B_EXTEN   = 1;
    localparam int B_RESTART = 2;
    localparam int B_HALTED  = 4;
    localparam int B_CAUSE   = 5;
    localparam int B_ERR     = 8;
    localparam int N_ERR     = 3;
    localparam int B_FULL    = 12;
endpackage

// File: rtl/hdbg_halt_ctrl.sv
// Halt entry/exit state. Qualifies events by enable and authentication,
// records the cause of the last halt, and honours restart only when no
// injected instruction is outstanding. Assumes events are single-cycle.
module hdbg_halt_ctrl
    import hdbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_bkpt,
    input  logic       ev_wpt,
    input  logic       ev_ereq,
    input  logic       en_hw,
    input  logic       en_ext,
    input  logic       sec_state,
    input  logic [1:0] auth_lvl,
    input  logic       restart_req,
    input  logic       itr_busy,
    output logic       halted,
    output cause_e     cause
);
    logic permit;
    logic hit_bk, hit_wp, hit_ex;

    // Authentication: level 1 covers non-secure only, level 2+ covers both.
    always_comb permit = (auth_lvl >= AUTH_ALL) || ((auth_lvl == AUTH_NS) && !sec_state);

    // Per-event enables.
    always_comb begin
        hit_bk = ev_bkpt && en_hw;
        hit_wp = ev_wpt  && en_hw;
        hit_ex = ev_ereq && en_ext;
    end

    // Halt state and cause register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
            cause  <= CAUSE_NONE;
        end else if (!halted) begin
            if (permit && (hit_bk || hit_wp || hit_ex)) begin
                halted <= 1'b1;
                if (hit_bk)      cause <= CAUSE_BKPT;
                else if (hit_wp) cause <= CAUSE_WPT;
                else             cause <= CAUSE_EREQ;
            end
        end else if (restart_req && !itr_busy) begin
            halted <= 1'b0;
        end
    end

    assert_auth_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($past(auth_lvl) >= AUTH_ALL) ||
                          (($past(auth_lvl) == AUTH_NS) && !$past(sec_state)));

    assert_restart_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> $past(restart_req) && !$past(itr_busy));

    assert_cause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halted) && halted |-> $stable(cause));
endmodule

// File: rtl/hdbg_itr.sv
// Instruction injection register. Accepts a word only while halted and empty,
// issues it with a one-cycle strobe, and stays full until the core
// acknowledges. Flags a write that arrives while full.
module hdbg_itr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept,
    input  logic              done,
    output logic              full,
    output logic              issue,
    output logic [DATA_W-1:0] insn,
    output logic              overrun
);
    logic load;

    // Write qualification and overrun detection.
    always_comb begin
        load    = wr && accept && !full;
        overrun = wr && full;
    end

    // Holding register, full flag and issue strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            issue <= 1'b0;
            insn  <= '0;
        end else begin
            issue <= load;
            if (load) begin
                full <= 1'b1;
                insn <= wdata;
            end else if (done) begin
                full <= 1'b0;
            end
        end
    end

    assert_issue_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);

    assert_issue_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> full);

    assert_insn_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(full) && full |-> $stable(insn));
endmodule

// File: rtl/hdbg_mbox.sv
// One-direction, single-entry mailbox. A write fills it, a take empties it;
// a write while full is dropped and reported as an overflow pulse.
module hdbg_mbox #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              overflow
);
    // Overflow indication for the sticky error bits.
    always_comb overflow = wr && full;

    // Slot data and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (full) begin
            if (take) full <= 1'b0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full && !take |=> full && $stable(data));
endmodule

// File: rtl/hdbg_ctrl.sv
// Halting debug controller top. Decodes the debug bus, holds the enables and
// sticky error bits, and ties together halt control, instruction injection
// and the two mailboxes. Assumes one bus access per cycle; read data is
// combinational in the cycle of bus_rd.
module hdbg_ctrl
    import hdbg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bkpt,
    input  logic              ev_wpt,
    input  logic              ev_ereq,
    input  logic              sec_state,
    input  logic [1:0]        auth_lvl,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              halted,
    output logic              fetch_stall,
    output logic              irq_mask,
    output logic              itr_issue,
    output logic [DATA_W-1:0] itr_insn,
    input  logic              itr_done,
    input  logic              core_rx_rd,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              core_rx_full,
    input  logic              core_tx_wr,
    input  logic [DATA_W-1:0] core_tx_data
);
    localparam int ADDR_N = 1 << ADDR_W;

    logic [ADDR_N-1:0] wsel;
    logic [ADDR_N-1:0] rsel;
    logic              en_hw_q, en_ext_q;
    logic [N_ERR-1:0]  err_q;
    logic [N_ERR-1:0]  err_set;
    logic [N_ERR-1:0]  err_clr;
    logic              restart_req;
    logic              itr_full, itr_ovr;
    logic              up_full, up_ovr, dn_ovr;
    logic [DATA_W-1:0] up_data;
    cause_e            cause;
    logic [DATA_W-1:0] status;

    // One-hot address decode for writes and reads.
    generate
        for (genvar a = 0; a < ADDR_N; a++) begin : g_dec
            assign wsel[a] = bus_wr && (bus_addr == ADDR_W'(a));
            assign rsel[a] = bus_rd && (bus_addr == ADDR_W'(a));
        end
    endgenerate

    // Control-write side effects.
    always_comb begin
        restart_req = wsel[ADDR_CTRL] && bus_wdata[B_RESTART];
        err_clr     = wsel[ADDR_CTRL] ? bus_wdata[B_ERR +: N_ERR] : '0;
        err_set     = {up_ovr, dn_ovr, itr_ovr};
    end

    // Enable bits and sticky errors (a new error wins over a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_hw_q  <= 1'b0;
            en_ext_q <= 1'b0;
            err_q    <= '0;
        end else begin
            if (wsel[ADDR_CTRL]) begin
                en_hw_q  <= bus_wdata[B_HWEN];
                en_ext_q <= bus_wdata[B_EXTEN];
            end
            err_q <= (err_q & ~err_clr) | err_set;
        end
    end

    hdbg_halt_ctrl u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_bkpt     (ev_bkpt),
        .ev_wpt      (ev_wpt),
        .ev_ereq     (ev_ereq),
        .en_hw       (en_hw_q),
        .en_ext      (en_ext_q),
        .sec_state   (sec_state),
        .auth_lvl    (auth_lvl),
        .restart_req (restart_req),
        .itr_busy    (itr_full),
        .halted      (halted),
        .cause       (cause)
    );

    hdbg_itr #(.DATA_W(DATA_W)) u_itr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wsel[ADDR_ITR]),
        .wdata   (bus_wdata),
        .accept  (halted),
        .done    (itr_done),
        .full    (itr_full),
        .issue   (itr_issue),
        .insn    (itr_insn),
        .overrun (itr_ovr)
    );

    hdbg_mbox #(.DATA_W(DATA_W)) u_dn (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wsel[ADDR_DN]),
        .wdata    (bus_wdata),
        .take     (core_rx_rd),
        .full     (core_rx_full),
        .data     (core_rx_data),
        .overflow (dn_ovr)
    );

    hdbg_mbox #(.DATA_W(DATA_W)) u_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (core_tx_wr),
        .wdata    (core_tx_data),
        .take     (rsel[ADDR_UP]),
        .full     (up_full),
        .data     (up_data),
        .overflow (up_ovr)
    );

    // Halt-dependent core controls.
    always_comb begin
        fetch_stall = halted;
        irq_mask    = halted;
    end

    // Status word assembly.
    always_comb begin
        status              = '0;
        status[B_HWEN]      = en_hw_q;
        status[B_EXTEN]     = en_ext_q;
        status[B_HALTED]    = halted;
        status[B_CAUSE +: 2] = cause;
        status[B_ERR +: N_ERR] = err_q;
        status[B_FULL]      = itr_full;
        status[B_FULL + 1]  = core_rx_full;
        status[B_FULL + 2]  = up_full;
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_W'(ADDR_CTRL): bus_rdata = status;
            ADDR_W'(ADDR_ITR):  bus_rdata = itr_insn;
            ADDR_W'(ADDR_DN):   bus_rdata = core_rx_data;
            default:            bus_rdata = up_data;
        endcase
    end

    assert_sticky_itr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[0]) |-> $past(itr_full) && $past(wsel[ADDR_ITR]));

    assert_sticky_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[2]) |-> $past(up_full) && $past(core_tx_wr));

    assert_up_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_full && rsel[ADDR_UP] |=> !up_full);
endmodule

// File: tb/tb_hdbg_ctrl.sv
// Directed bench for hdbg_ctrl: one task per scenario, inputs driven and
// outputs sampled on the falling edge.
module tb_hdbg_ctrl;
    localparam int DW = 32;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_bkpt = 0, ev_wpt = 0, ev_ereq = 0, sec_state = 0;
    logic [1:0]    auth_lvl = 2'd0;
    logic          bus_wr = 0, bus_rd = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          halted, fetch_stall, irq_mask, itr_issue;
    logic [DW-1:0] itr_insn;
    logic          itr_done = 0, core_rx_rd = 0, core_tx_wr = 0;
    logic [DW-1:0] core_rx_data;
    logic          core_rx_full;
    logic [DW-1:0] core_tx_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hdbg_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut (.*);

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [DW-1:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input int a, output logic [DW-1:0] d);
        bus_addr = AW'(a); bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pulse_ev(input logic b, input logic w, input logic e);
        ev_bkpt = b; ev_wpt = w; ev_ereq = e;
        @(negedge clk);
        ev_bkpt = 0; ev_wpt = 0; ev_ereq = 0;
    endtask

    function automatic logic [1:0] cause_of(input logic [DW-1:0] s);
        return s[6:5];
    endfunction

    task automatic t_reset();
        logic [DW-1:0] s;
        chk("R1 halted", DW'(halted), 0);
        chk("R1 stall", DW'(fetch_stall), 0);
        chk("R1 mask", DW'(irq_mask), 0);
        chk("R1 issue", DW'(itr_issue), 0);
        chk("R1 rx_full", DW'(core_rx_full), 0);
        bus_read(0, s);
        chk("R1 status", s, 0);
    endtask

    task automatic t_hw_gate();
        logic [DW-1:0] s;
        auth_lvl = 2'd3; sec_state = 0;
        pulse_ev(1, 0, 0);
        chk("R2 bkpt without enable", DW'(halted), 0);
        bus_write(0, 32'h1);
        pulse_ev(1, 0, 0);
        chk("R2 bkpt halts", DW'(halted), 1);
        chk("R5 stall", DW'(fetch_stall), 1);
        chk("R5 mask", DW'(irq_mask), 1);
        bus_read(0, s);
        chk("R11 halted bit", DW'(s[4]), 1);
        chk("R3 cause bkpt", DW'(cause_of(s)), 1);
        pulse_ev(0, 1, 0);
        bus_read(0, s);
        chk("R5 cause kept", DW'(cause_of(s)), 1);
        chk("R5 still halted", DW'(fetch_stall), 1);
        bus_write(0, 32'h5);
        chk("R10 restart", DW'(halted), 0);
        chk("R10 stall low", DW'(fetch_stall), 0);
        chk("R10 mask low", DW'(irq_mask), 0);
        pulse_ev(0, 1, 0);
        bus_read(0, s);
        chk("R2 wpt cause", DW'(cause_of(s)), 2);
        bus_write(0, 32'h5);
    endtask

    task automatic t_ext();
        logic [DW-1:0] s;
        pulse_ev(0, 0, 1);
        chk("R3 ereq without enable", DW'(halted), 0);
        bus_write(0, 32'h2);
        pulse_ev(1, 0, 0);
        chk("R2 hw enable cleared", DW'(halted), 0);
        pulse_ev(0, 0, 1);
        bus_read(0, s);
        chk("R3 cause ereq", DW'(cause_of(s)), 3);
        bus_write(0, 32'h7);
        pulse_ev(0, 1, 1);
        bus_read(0, s);
        chk("R3 wpt over ereq", DW'(cause_of(s)), 2);
        bus_write(0, 32'h7);
        pulse_ev(1, 1, 1);
        bus_read(0, s);
        chk("R3 bkpt priority", DW'(cause_of(s)), 1);
        bus_write(0, 32'h7);
    endtask

    task automatic t_auth();
        auth_lvl = 2'd0; sec_state = 0;
        pulse_ev(1, 0, 0);
        chk("R4 level 0", DW'(halted), 0);
        auth_lvl = 2'd3;
        @(negedge clk); @(negedge clk);
        chk("R4 dropped not pending", DW'(halted), 0);
        auth_lvl = 2'd1; sec_state = 1;
        pulse_ev(0, 0, 1);
        chk("R4 level 1 secure", DW'(halted), 0);
        sec_state = 0;
        pulse_ev(0, 0, 1);
        chk("R4 level 1 non-secure", DW'(halted), 1);
        bus_write(0, 32'h7);
        auth_lvl = 2'd2; sec_state = 1;
        pulse_ev(1, 0, 0);
        chk("R4 level 2 secure", DW'(halted), 1);
        bus_write(0, 32'h7);
        sec_state = 0; auth_lvl = 2'd3;
    endtask

    task automatic t_itr();
        logic [DW-1:0] s;
        bus_write(1, 32'hDEAD);
        bus_read(0, s);
        chk("R6 write ignored when running", DW'(s[12]), 0);
        chk("R6 no issue when running", DW'(itr_issue), 0);
        pulse_ev(1, 0, 0);
        bus_write(1, 32'hA5);
        chk("R6 issue strobe", DW'(itr_issue), 1);
        chk("R6 insn", itr_insn, 32'hA5);
        @(negedge clk);
        chk("R6 strobe one cycle", DW'(itr_issue), 0);
        bus_write(1, 32'h5A);
        chk("R7 no issue on overrun", DW'(itr_issue), 0);
        chk("R7 insn kept", itr_insn, 32'hA5);
        bus_read(0, s);
        chk("R7 overrun bit", DW'(s[8]), 1);
        chk("R6 full bit", DW'(s[12]), 1);
        bus_write(0, 32'h7);
        chk("R10 restart refused while full", DW'(halted), 1);
        itr_done = 1; @(negedge clk); itr_done = 0;
        bus_read(0, s);
        chk("R6 done clears full", DW'(s[12]), 0);
        bus_write(0, 32'h103);
        bus_read(0, s);
        chk("R11 overrun cleared", DW'(s[8]), 0);
        chk("R11 still halted", DW'(s[4]), 1);
        bus_write(0, 32'h7);
        chk("R10 restart after done", DW'(halted), 0);
    endtask

    task automatic t_mbox();
        logic [DW-1:0] s, d;
        bus_write(2, 32'h11);
        chk("R8 rx full", DW'(core_rx_full), 1);
        chk("R8 rx data", core_rx_data, 32'h11);
        bus_write(2, 32'h22);
        chk("R8 data kept", core_rx_data, 32'h11);
        core_rx_rd = 1; @(negedge clk); core_rx_rd = 0;
        chk("R8 take empties", DW'(core_rx_full), 0);
        core_tx_data = 32'h33; core_tx_wr = 1; @(negedge clk);
        core_tx_data = 32'h44; @(negedge clk); core_tx_wr = 0;
        bus_read(0, s);
        chk("R8 overflow bit", DW'(s[9]), 1);
        chk("R9 tx full bit", DW'(s[14]), 1);
        chk("R9 overflow bit", DW'(s[10]), 1);
        bus_read(3, d);
        chk("R9 data", d, 32'h33);
        bus_read(0, s);
        chk("R9 read empties", DW'(s[14]), 0);
        bus_write(0, 32'h603);
        bus_read(0, s);
        chk("R11 errors cleared", DW'(s[10:8]), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_hw_gate();
        t_ext();
        t_auth();
        t_itr();
        t_mbox();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule